// File: doc/BRIEF.md
# Configurable interrupt pin generator

This block turns a vector of single-cycle event pulses into one interrupt output pin. Every event lands in a sticky status bit. The status bits fall into three groups. Bus-status and end-of-transfer bits are cleared by reading the status word. A pseudo start-of-frame bit belongs to the same clear-on-read group. Endpoint bits are cleared only by their own clear strobe. The status bits are ANDed with a per-bit enable mask and then ORed together to form the pending request. A small register port holds the mask and a control word. The control word has three bits: a global enable, a polarity bit and a level/pulse bit.

The global enable does not gate the pin. It acts as a latch: while it is 0 the pin keeps whatever value it had. This means the pin can be frozen in the asserted state. In pulse mode the pin is active for a fixed number of clock cycles (`PULSE_CYC`) each time the gated pending request rises.

A supervisor watches the start-of-frame input. Once a real start-of-frame has armed it, each frame interval of `FRAME_CYC` cycles that passes without one produces a pseudo start-of-frame event. After `MISS_LIMIT` consecutive misses the supervisor raises a suspend output.

The pin state machine has three states:
- PIN_IDLE (pin inactive). It goes to PIN_LEVEL in level mode when a request is pending, or to PIN_PULSE in pulse mode on a rise of the gated request.
- PIN_LEVEL (pin active). It returns to PIN_IDLE when the request clears or pulse mode is selected.
- PIN_PULSE (pin active while a countdown runs). When the countdown ends it goes to PIN_IDLE, or to PIN_LEVEL if level mode is selected and a request is pending.

The pin state machine makes no transition while the global enable is 0.

The supervisor has three states:
- SV_UNARMED. A real start-of-frame moves it to SV_TRACK.
- SV_TRACK. A miss that brings the count to `MISS_LIMIT` moves it to SV_SUSPEND.
- SV_SUSPEND. It keeps producing pseudo events.

A real start-of-frame sends the supervisor from any state to SV_TRACK.

Top module: `irq_pin_gen`

## Requirements
- R1: After reset the mask, the control word and all status bits are 0. The pin is high, meaning level mode, active low, inactive. Suspend is 0. `cfg_rdata` returns the mask when `cfg_addr`=0 and the zero-extended control word when `cfg_addr`=1.
- R2: Status bit layout: bits [NB-1:0] are bus events, bit NB is pseudo-SOF, and bits [NB+NE:NB+1] are endpoint events. An event pulse sets its status bit at the next clock edge whatever the mask and global enable are. A set in the same cycle as a clear wins.
- R3: A cycle with `stat_rd`=1 clears the bus and pseudo-SOF bits at the next edge and leaves the endpoint bits unchanged. `stat_rdata` always shows the current status.
- R4: `ep_clr[j]`=1 clears endpoint status bit j only.
- R5: Control bit 0 is the global enable, bit 1 is polarity (1 = active high) and bit 2 is pulse mode. In level mode with the global enable at 1, the pin is active from the edge after an enabled status bit becomes pending until the edge after no enabled bit is pending. Masked bits never assert the pin.
- R6: In pulse mode, a 0-to-1 change of (pending AND global enable) makes the pin active for exactly `PULSE_CYC` cycles, starting at the next edge. Further events while the request stays high do not start a new pulse.
- R7: While the global enable is 0 the pin holds its value. This holds across new events, status clears and polarity changes, so an asserted pin stays asserted.
- R8: Writing the global enable to 1 while an enabled bit is pending activates the pin at the next edge.
- R9: The inactive pin level is the inverse of the polarity bit and the active level equals it, in both level and pulse mode.
- R10: After the first real start-of-frame, each run of `FRAME_CYC` cycles without one sets the pseudo-SOF status bit. It is never set before the first real start-of-frame.
- R11: `suspend` rises at the edge that records the `MISS_LIMIT`-th consecutive pseudo-SOF.
- R12: A real start-of-frame clears `suspend`, the miss count and the frame timer at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_bus | input | NB | Bus-status / end-of-transfer event pulses |
| evt_ep | input | NE | Endpoint event pulses |
| sof_evt | input | 1 | Real start-of-frame pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = enable mask, 1 = control word |
| cfg_wdata | input | NB+1+NE | Register write data |
| cfg_rdata | output | NB+1+NE | Register read data |
| stat_rd | input | 1 | Status read strobe (clears the clear-on-read group) |
| stat_rdata | output | NB+1+NE | Current status bits |
| ep_clr | input | NE | Per-endpoint status clear strobes |
| irq_pin | output | 1 | Interrupt output pin |
| suspend | output | 1 | Missed-frame suspend indication |

## Verification
The bench sweeps all four polarity and level/pulse combinations. In each combination it checks the idle level, a pulse that lasts exactly `PULSE_CYC` cycles with no retrigger, and a level that holds until the status is read. It also disables the global enable with the pin idle and with the pin asserted, then changes status and polarity. A design that merely gated the pin would drop it at once. A design that ignored the latch would follow the polarity flip. The bench also drives a set and a clear into the same bit in the same cycle, and reads status while endpoint bits are pending. These catch a clear that wins over a set and a read that wipes endpoint bits. The supervisor is timed to the exact cycle: before it is armed, on each pseudo-SOF, on the rise of suspend, and after a start-of-frame arrives mid-frame. An off-by-one frame counter, or a timer that does not restart, shows up as a pseudo-SOF bit one cycle early or late.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        PIN_IDLE,
        PIN_LEVEL,
        PIN_PULSE
    } pin_state_e;

    typedef enum logic [1:0] {
        SV_UNARMED,
        SV_TRACK,
        SV_SUSPEND
    } sv_state_e;

    localparam int CTL_GEN   = 0;
    localparam int CTL_POL   = 1;
    localparam int CTL_PULSE = 2;
    localparam int CTL_W     = 3;

endpackage

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
    parameter int NB = 3,
    parameter int NE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB+NE:0]       set_vec,
    input  logic                 rd_clr,
    input  logic [NE-1:0]        ep_clr,
    output logic [NB+NE:0]       status
);
    localparam int SW = NB + 1 + NE;

    logic [SW-1:0] clr_vec;
    logic [SW-1:0] st_q;

    // clear-on-read group (bus + pseudo-SOF), then per-endpoint clears
    assign clr_vec = {ep_clr, {(NB + 1){rd_clr}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= (st_q & ~clr_vec) | set_vec;
        end
    end

    assign status = st_q;

    for (genvar i = 0; i < SW; i++) begin : g_set_chk
        p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> status[i]);
    end

    for (genvar i = 0; i <= NB; i++) begin : g_read_chk
        p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !set_vec[i]) |=> !status[i]);
    end

    for (genvar j = 0; j < NE; j++) begin : g_ep_chk
        p_ep_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (status[NB+1+j] && !ep_clr[j]) |=> status[NB+1+j]);
    end

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_pkg::*;
#(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    input  logic glob_en,
    input  logic pol_high,
    input  logic pulse_mode,
    output logic irq_pin
);
    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

    pin_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          prev_q;
    logic          pin_q;
    logic          gated;
    logic          rise;
    logic          active_d;

    assign gated = pend_any & glob_en;
    assign rise  = gated & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= gated;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (glob_en) begin
            unique case (state_q)
                PIN_IDLE: begin
                    if (pulse_mode) begin
                        if (rise) begin
                            state_d = PIN_PULSE;
                            cnt_d   = CNT_LOAD;
                        end
                    end else if (pend_any) begin
                        state_d = PIN_LEVEL;
                    end
                end
                PIN_LEVEL: begin
                    if (pulse_mode || !pend_any) state_d = PIN_IDLE;
                end
                PIN_PULSE: begin
                    if (cnt_q == '0) begin
                        state_d = (!pulse_mode && pend_any) ? PIN_LEVEL : PIN_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = PIN_IDLE;
            endcase
        end
    end

    assign active_d = (state_d != PIN_IDLE);

    // output register: the global enable latches it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else if (glob_en) begin
            pin_q <= pol_high ? active_d : ~active_d;
        end
    end

    assign irq_pin = pin_q;

    p_pin_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> $stable(irq_pin));

    p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && pulse_mode && rise && state_q == PIN_IDLE) |=> (irq_pin == $past(pol_high)));

    p_level_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && !pulse_mode && pend_any) |=> (irq_pin == $past(pol_high)));

endmodule

// File: rtl/sof_supervisor.sv
module sof_supervisor
    import irq_pkg::*;
#(
    parameter int FRAME_CYC  = 48000,
    parameter int MISS_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    output logic psof,
    output logic suspend
);
    localparam int FW = $clog2(FRAME_CYC + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_CYC - 1);
    localparam logic [MW-1:0] MISS_LAST  = MW'(MISS_LIMIT - 1);

    sv_state_e     state_q, state_d;
    logic [FW-1:0] frame_q, frame_d;
    logic [MW-1:0] miss_q, miss_d;
    logic          fire;

    assign fire = (state_q != SV_UNARMED) && !sof && (frame_q == FRAME_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SV_UNARMED;
            frame_q <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_d;
            miss_q  <= miss_d;
        end
    end

    always_comb begin
        state_d = state_q;
        frame_d = frame_q;
        miss_d  = miss_q;
        if (sof) begin
            state_d = SV_TRACK;
            frame_d = '0;
            miss_d  = '0;
        end else begin
            unique case (state_q)
                SV_UNARMED: ;
                SV_TRACK: begin
                    if (fire) begin
                        frame_d = '0;
                        miss_d  = miss_q + 1'b1;
                        if (miss_q == MISS_LAST) state_d = SV_SUSPEND;
                    end else begin
                        frame_d = frame_q + 1'b1;
                    end
                end
                SV_SUSPEND: begin
                    frame_d = fire ? '0 : frame_q + 1'b1;
                end
                default: state_d = SV_UNARMED;
            endcase
        end
    end

    assign psof    = fire;
    assign suspend = (state_q == SV_SUSPEND);

    p_sof_wakes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !suspend);

    p_suspend_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspend) |-> $past(psof));

    p_psof_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (psof && FRAME_CYC > 1) |=> !psof);

endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen
    import irq_pkg::*;
#(
    parameter int NB         = 3,
    parameter int NE         = 4,
    parameter int PULSE_CYC  = 8,
    parameter int FRAME_CYC  = 48000,
    parameter int MISS_LIMIT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NB-1:0]      evt_bus,
    input  logic [NE-1:0]      evt_ep,
    input  logic               sof_evt,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [NB+NE:0]     cfg_wdata,
    output logic [NB+NE:0]     cfg_rdata,
    input  logic               stat_rd,
    output logic [NB+NE:0]     stat_rdata,
    input  logic [NE-1:0]      ep_clr,
    output logic               irq_pin,
    output logic               suspend
);
    localparam int SW = NB + 1 + NE;

    logic [SW-1:0]    mask_q;
    logic [CTL_W-1:0] ctrl_q;
    logic [SW-1:0]    status;
    logic [SW-1:0]    set_vec;
    logic             psof;
    logic             pend_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr) ctrl_q <= cfg_wdata[CTL_W-1:0];
            else          mask_q <= cfg_wdata;
        end
    end

    assign cfg_rdata = cfg_addr ? SW'(ctrl_q) : mask_q;
    assign set_vec   = {evt_ep, psof, evt_bus};
    assign pend_any  = |(status & mask_q);

    sof_supervisor #(
        .FRAME_CYC  (FRAME_CYC),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_sof (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (sof_evt),
        .psof    (psof),
        .suspend (suspend)
    );

    irq_status_regs #(
        .NB (NB),
        .NE (NE)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd_clr  (stat_rd),
        .ep_clr  (ep_clr),
        .status  (status)
    );

    irq_pin_fsm #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any   (pend_any),
        .glob_en    (ctrl_q[CTL_GEN]),
        .pol_high   (ctrl_q[CTL_POL]),
        .pulse_mode (ctrl_q[CTL_PULSE]),
        .irq_pin    (irq_pin)
    );

    assign stat_rdata = status;

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTL_GEN] && !ctrl_q[CTL_PULSE] && !pend_any && $past(!pend_any))
            |=> (irq_pin == !$past(ctrl_q[CTL_POL])));

endmodule

// File: tb/irq_pin_gen_tb.sv
module irq_pin_gen_tb;
    localparam int NB = 3;
    localparam int NE = 4;
    localparam int SW = NB + 1 + NE;
    localparam int P  = 5;
    localparam int F  = 40;
    localparam int ML = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] evt_bus = '0;
    logic [NE-1:0] evt_ep = '0;
    logic          sof_evt = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [SW-1:0] cfg_wdata = '0;
    logic [SW-1:0] cfg_rdata;
    logic          stat_rd = 1'b0;
    logic [SW-1:0] stat_rdata;
    logic [NE-1:0] ep_clr = '0;
    logic          irq_pin;
    logic          suspend;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    always #4 clk = ~clk;

    irq_pin_gen #(
        .NB(NB), .NE(NE), .PULSE_CYC(P), .FRAME_CYC(F), .MISS_LIMIT(ML)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .evt_ep(evt_ep),
        .sof_evt(sof_evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .ep_clr(ep_clr), .irq_pin(irq_pin),
        .suspend(suspend)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(input logic a, input logic [SW-1:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_bus(input int i);
        evt_bus[i] = 1'b1; cyc(1); evt_bus = '0;
    endtask

    task automatic pulse_ep(input int i);
        evt_ep[i] = 1'b1; cyc(1); evt_ep = '0;
    endtask

    task automatic rd_pulse();
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    endtask

    task automatic clr_all();
        stat_rd = 1'b1; ep_clr = '1; cyc(1); stat_rd = 1'b0; ep_clr = '0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 pin", irq_pin, 1);
        check("R1 suspend", suspend, 0);
        check("R1 status", stat_rdata, 0);
        cfg_addr = 1'b0; #1;
        check("R1 mask", cfg_rdata, 0);
        cfg_addr = 1'b1; #1;
        check("R1 ctrl", cfg_rdata, 0);

        // R2 set wins over same-cycle clear (pin disabled, events still recorded)
        evt_bus[0] = 1'b1; stat_rd = 1'b1; cyc(1); evt_bus = '0; stat_rd = 1'b0;
        check("R2 bus set wins", stat_rdata[0], 1);
        evt_ep[1] = 1'b1; ep_clr[1] = 1'b1; cyc(1); evt_ep = '0; ep_clr = '0;
        check("R2 ep set wins", stat_rdata[5], 1);
        check("R7 disabled pin idle", irq_pin, 1);
        // R3 read clears bus group only
        rd_pulse();
        check("R3 read keeps ep", stat_rdata, 8'b0010_0000);
        // R4 per-endpoint clear
        evt_ep = 4'b0101; cyc(1); evt_ep = '0;
        ep_clr = 4'b0011; cyc(1); ep_clr = '0;
        check("R4 ep clear", stat_rdata, 8'b0100_0000);
        clr_all();
        check("R3 R4 all clear", stat_rdata, 0);

        // R5 masking in level active-low
        wcfg(1'b0, 8'h01);
        wcfg(1'b1, 8'h01);
        cfg_addr = 1'b1; #1;
        check("R1 ctrl readback", cfg_rdata, 1);
        pulse_bus(1); cyc(1);
        check("R5 masked bit quiet", irq_pin, 1);
        wcfg(1'b0, 8'h02); cyc(1);
        check("R5 unmasked asserts", irq_pin, 0);
        clr_all(); cyc(1);
        check("R5 clear deasserts", irq_pin, 1);

        // sweep all four modes
        for (int m = 0; m < 4; m++) begin
            logic pol, pls, act, idl;
            int   n_act;
            pol = m[0]; pls = m[1]; act = pol; idl = ~pol;
            wcfg(1'b0, 8'hFF);
            wcfg(1'b1, {5'b0, pls, pol, 1'b1});
            cyc(1);
            check("R9 idle level", irq_pin, idl);
            pulse_bus(1); cyc(1);
            check("R9 active level", irq_pin, act);
            if (pls) begin
                n_act = 1;
                for (int k = 0; k < P; k++) begin
                    cyc(1);
                    if (irq_pin == act) n_act++;
                end
                check("R6 pulse width", n_act, P);
                pulse_bus(0); cyc(2);
                check("R6 no retrigger", irq_pin, idl);
            end else begin
                cyc(3);
                check("R5 level holds", irq_pin, act);
            end
            rd_pulse(); cyc(1);
            check("R5 cleared idle", irq_pin, idl);

            // enable toggling
            wcfg(1'b1, {5'b0, pls, pol, 1'b0});
            pulse_ep(2); cyc(3);
            check("R7 disabled stays idle", irq_pin, idl);
            check("R2 recorded while disabled", stat_rdata[6], 1);
            wcfg(1'b1, {5'b0, pls, pol, 1'b1}); cyc(1);
            check("R8 enable asserts", irq_pin, act);
            wcfg(1'b1, {5'b0, pls, pol, 1'b0});
            ep_clr[2] = 1'b1; cyc(1); ep_clr = '0;
            cyc(P + 3);
            check("R7 frozen asserted", irq_pin, act);
            wcfg(1'b1, {5'b0, pls, ~pol, 1'b0}); cyc(1);
            check("R7 polarity change frozen", irq_pin, act);
            wcfg(1'b1, {5'b0, pls, pol, 1'b1}); cyc(P + 1);
            check("R7 re-enable releases", irq_pin, idl);
            clr_all();
        end

        // supervisor
        wcfg(1'b1, 8'h00);
        clr_all();
        cyc(3 * F);
        check("R10 unarmed no psof", stat_rdata[3], 0);
        check("R11 unarmed no suspend", suspend, 0);
        sof_evt = 1'b1; cyc(1); sof_evt = 1'b0;
        cyc(F - 1);
        check("R10 psof not early", stat_rdata[3], 0);
        cyc(1);
        check("R10 psof on time", stat_rdata[3], 1);
        cyc(2 * F - 1);
        check("R11 suspend not early", suspend, 0);
        cyc(1);
        check("R11 suspend on third miss", suspend, 1);
        rd_pulse();
        sof_evt = 1'b1; cyc(1); sof_evt = 1'b0;
        check("R12 sof clears suspend", suspend, 0);
        check("R3 psof cleared by read", stat_rdata[3], 0);
        cyc(20);
        sof_evt = 1'b1; cyc(1); sof_evt = 1'b0;
        cyc(F - 1);
        check("R12 timer restarted", stat_rdata[3], 0);
        cyc(1);
        check("R12 psof after restart", stat_rdata[3], 1);
        cyc(F);
        check("R12 miss count restarted", suspend, 0);

        summary();
        $finish;
    end
endmodule